// File: doc/BRIEF.md
# Odd/Even Line Inversion Bus Codec

This block sends data words over a parallel on-chip bus whose neighbouring wires are capacitively coupled. For every accepted word the encoder looks at four ways to drive it: unchanged, with only the odd-indexed wires flipped, with only the even-indexed wires flipped, or with every wire flipped. It scores each against the word now sitting on the bus with a coupling cost over adjacent wire pairs. It keeps the cheapest, registers it, and drives it together with a two-bit mode code.

A receive-side decoder sits on the registered bus and mode lines. It flips the same wire groups back, so the original word is available in the cycle the coded word appears. The coded state of the bus only moves when the input strobe is high.

Top module: `oe_invert_codec`

## Requirements
- R1: While reset is asserted (active low) and after it is released with no accepted word, the bus lines, the mode lines and the decoded output are all zero.
- R2: When the valid strobe is low at a clock edge, the bus lines, mode lines and decoded output keep their values whatever the data input does.
- R3: The mode code is two bits. Bit 1 set means every odd-indexed wire (index 1, 3, 5, ...) is driven inverted. Bit 0 set means every even-indexed wire (index 0, 2, 4, ...) is driven inverted. So 00 means none, 10 odd only, 01 even only and 11 all.
- R4: The cost of a candidate against the previous bus word is summed over each adjacent pair (i, i+1). A pair costs 0 if neither wire changes, 1 if exactly one changes, 0 if both change in the same direction, and 4 if both change in opposite directions.
- R5: The driven mode is one whose candidate has the lowest cost against the previously driven bus word.
- R6: Among equal-cost candidates the order of preference is none, then odd only, then even only, then all.
- R7: The decoded output equals the data word accepted at the most recent valid edge, in the same cycle as the coded word appears on the bus.
- R8: A word accepted at a clock edge appears, coded, on the bus and mode lines right after that edge: there is one register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dataValid | input | 1 | Accept strobe for dataIn |
| dataIn | input | DataW | Word to send |
| busOut | output | DataW | Coded word driven on the wires |
| modeOut | output | 2 | Inversion mode code (bit 1 odd, bit 0 even) |
| decodedOut | output | DataW | Word recovered from busOut and modeOut |

## Verification
On every cycle the assertions check four things. The register holds when the strobe is low. The selected candidate's cost is no higher than any other. The tie order is honoured. The decoder returns the word accepted one edge earlier. Only the bench scenarios show the rest. These are the cost weights themselves, the exact mode codes and wire polarities, and the reset values. The bench covers them by replaying every ordered pair of words of a four-bit configuration against an arithmetic model of the pair costs.

// File: rtl/oe_invert_pkg.sv
package oe_invert_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_EVEN  = 2'b01,
    MODE_ODD   = 2'b10,
    MODE_ALL   = 2'b11
  } mode_e;

  typedef struct packed {
    logic  load;
    mode_e mode;
  } strobe_t;

  // preference rank 0..3 to mode code
  function automatic mode_e rankMode(input int rank);
    case (rank)
      0:       return MODE_PLAIN;
      1:       return MODE_ODD;
      2:       return MODE_EVEN;
      default: return MODE_ALL;
    endcase
  endfunction

endpackage

// File: rtl/oe_pair_cost.sv
module oe_pair_cost #(
  parameter int DataW = 8,
  parameter int CostW = 5
) (
  input  logic [DataW-1:0] prevWord,
  input  logic [DataW-1:0] candWord,
  output logic [CostW-1:0] cost
);
  localparam int Pairs = DataW - 1;

  logic [Pairs-1:0][2:0] pairCost;

  for (genvar i = 0; i < Pairs; i++) begin : g_pair
    logic flipLo, flipHi;
    assign flipLo = prevWord[i] ^ candWord[i];
    assign flipHi = prevWord[i+1] ^ candWord[i+1];
    always_comb begin
      if (flipLo && flipHi)
        pairCost[i] = (candWord[i] != candWord[i+1]) ? 3'd4 : 3'd0;
      else if (flipLo || flipHi)
        pairCost[i] = 3'd1;
      else
        pairCost[i] = 3'd0;
    end
  end

  always_comb begin
    cost = '0;
    for (int i = 0; i < Pairs; i++) cost = cost + CostW'(pairCost[i]);
  end
endmodule

// File: rtl/oe_select_ctrl.sv
module oe_select_ctrl
  import oe_invert_pkg::*;
#(
  parameter int CostW = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  dataValid,
  input  logic [3:0][CostW-1:0] rankCost,
  output strobe_t               strobe
);
  logic [1:0] bestRank;

  always_comb begin
    bestRank = 2'd0;
    for (int k = 1; k < 4; k++)
      if (rankCost[k] < rankCost[bestRank]) bestRank = 2'(k);
  end

  assign strobe.load = dataValid;
  assign strobe.mode = rankMode(int'(bestRank));

  assert_min_cost_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (rankCost[bestRank] <= rankCost[0]) && (rankCost[bestRank] <= rankCost[1])
                 && (rankCost[bestRank] <= rankCost[2]) && (rankCost[bestRank] <= rankCost[3]));

  assert_tie_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |->
      ((strobe.mode == MODE_PLAIN)
       || (strobe.mode == MODE_ODD  && rankCost[0] > rankCost[1])
       || (strobe.mode == MODE_EVEN && rankCost[0] > rankCost[2] && rankCost[1] > rankCost[2])
       || (strobe.mode == MODE_ALL  && rankCost[0] > rankCost[3] && rankCost[1] > rankCost[3]
                                    && rankCost[2] > rankCost[3])));
endmodule

// File: rtl/oe_encode_path.sv
module oe_encode_path
  import oe_invert_pkg::*;
#(
  parameter int DataW = 8,
  parameter int CostW = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DataW-1:0]      dataIn,
  input  strobe_t               strobe,
  output logic [3:0][CostW-1:0] rankCost,
  output logic [DataW-1:0]      busReg,
  output logic [1:0]            modeReg
);
  logic [DataW-1:0] oddMask;
  logic [3:0][DataW-1:0] cand;

  always_comb
    for (int i = 0; i < DataW; i++) oddMask[i] = i[0];

  for (genvar k = 0; k < 4; k++) begin : g_cand
    localparam mode_e CandMode = rankMode(k);
    assign cand[k] = dataIn ^ ({DataW{CandMode[1]}} & oddMask)
                            ^ ({DataW{CandMode[0]}} & ~oddMask);
    oe_pair_cost #(.DataW(DataW), .CostW(CostW)) u_cost (
      .prevWord(busReg),
      .candWord(cand[k]),
      .cost    (rankCost[k])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busReg  <= '0;
      modeReg <= '0;
    end else if (strobe.load) begin
      busReg  <= dataIn ^ ({DataW{strobe.mode[1]}} & oddMask)
                        ^ ({DataW{strobe.mode[0]}} & ~oddMask);
      modeReg <= strobe.mode;
    end
  end

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(busReg) && $stable(modeReg));
endmodule

// File: rtl/oe_decode.sv
module oe_decode #(
  parameter int DataW = 8
) (
  input  logic [DataW-1:0] busWord,
  input  logic [1:0]       modeBits,
  output logic [DataW-1:0] plainWord
);
  always_comb
    for (int i = 0; i < DataW; i++)
      plainWord[i] = busWord[i] ^ (i[0] ? modeBits[1] : modeBits[0]);
endmodule

// File: rtl/oe_invert_codec.sv
module oe_invert_codec
  import oe_invert_pkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataValid,
  input  logic [DataW-1:0] dataIn,
  output logic [DataW-1:0] busOut,
  output logic [1:0]       modeOut,
  output logic [DataW-1:0] decodedOut
);
  localparam int MaxCost = 4 * (DataW - 1);
  localparam int CostW   = $clog2(MaxCost + 1);

  strobe_t               strobe;
  logic [3:0][CostW-1:0] rankCost;

  oe_select_ctrl #(.CostW(CostW)) u_ctrl (
    .clk(clk), .rstN(rstN), .dataValid(dataValid),
    .rankCost(rankCost), .strobe(strobe)
  );

  oe_encode_path #(.DataW(DataW), .CostW(CostW)) u_path (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobe(strobe),
    .rankCost(rankCost), .busReg(busOut), .modeReg(modeOut)
  );

  oe_decode #(.DataW(DataW)) u_dec (
    .busWord(busOut), .modeBits(modeOut), .plainWord(decodedOut)
  );

  assert_decode_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> decodedOut == $past(dataIn));
endmodule

// File: tb/oe_invert_codec_test.sv
module oe_invert_codec_test;
  localparam int W = 4;

  logic clk = 0;
  logic rstN = 0;
  logic dataValid = 0;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] busOut, decodedOut;
  logic [1:0] modeOut;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] modelBus = '0;
  logic [1:0] modelMode = '0;

  always #5 clk = ~clk;

  oe_invert_codec #(.DataW(W)) uut (
    .clk(clk), .rstN(rstN), .dataValid(dataValid), .dataIn(dataIn),
    .busOut(busOut), .modeOut(modeOut), .decodedOut(decodedOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pairSum(input logic [W-1:0] p, input logic [W-1:0] c);
    int s = 0;
    for (int i = 0; i + 1 < W; i++) begin
      int a = int'(c[i]) - int'(p[i]);
      int b = int'(c[i+1]) - int'(p[i+1]);
      if (a * b < 0) s += 4;
      else if ((a == 0) != (b == 0)) s += 1;
    end
    return s;
  endfunction

  function automatic logic [W-1:0] applyMode(input logic [W-1:0] d, input logic [1:0] m);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = d[i] ^ ((i % 2 == 1) ? m[1] : m[0]);
    return r;
  endfunction

  task automatic sendWord(input logic [W-1:0] d);
    logic [1:0] order [4] = '{2'b00, 2'b10, 2'b01, 2'b11};
    int best = 1 << 30;
    logic [1:0] pick = 2'b00;
    for (int k = 0; k < 4; k++) begin
      int c = pairSum(modelBus, applyMode(d, order[k]));
      if (c < best) begin best = c; pick = order[k]; end
    end
    modelMode = pick;
    modelBus = applyMode(d, pick);
    dataIn = d;
    dataValid = 1;
    @(negedge clk);
    dataValid = 0;
    check("R4 R5 R6 mode", modeOut, modelMode);
    check("R3 R8 bus", busOut, modelBus);
    check("R7 decoded", decodedOut, d);
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 bus in reset", busOut, 0);
    check("R1 mode in reset", modeOut, 0);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 bus after reset", busOut, 0);
    check("R1 mode after reset", modeOut, 0);
    check("R1 decoded after reset", decodedOut, 0);

    // from all-zero bus, 0101: odd and even flips both cost 0, odd wins (R6)
    sendWord(4'b0101);
    check("R6 tie odd first mode", modeOut, 2'b10);
    check("R6 tie odd first bus", busOut, 4'b1111);

    // idle strobe: nothing moves (R2)
    for (int n = 0; n < 3; n++) begin
      dataIn = 4'(n * 5 + 3);
      @(negedge clk);
      check("R2 bus held", busOut, 4'b1111);
      check("R2 mode held", modeOut, 2'b10);
      check("R2 decoded held", decodedOut, 4'b0101);
    end

    // every ordered pair of words
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++) begin
        sendWord(W'(a));
        sendWord(W'(b));
      end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule